// File: doc/BRIEF.md
# Halt and active-halt sequencer

This block parks a small microcontroller core when the core decodes its halt opcode, and brings it back later. On each halt it picks one of two flavours from the current timer control bits. In plain halt every clock is stopped and only an external interrupt can revive the core. In active-halt the oscillator and the wake-up timer keep running, so timer interrupts can also end the halt. The peripheral clock enables drop in both flavours, and the CPU is held by a stall output until it may run again.

Two kinds of exit exist. An interrupt exit frees the CPU on the next clock and reports which interrupt woke it. A reset exit (the block's own reset) first runs a start-up delay of 256 or 4096 oscillator cycles, chosen by a configuration bit, and then tells the CPU to fetch the reset vector. The block also owns the CPU interrupt mask: halt entry clears it, reset sets it, and the CPU may write it while running. A halt attempted while the watchdog runs and active-halt is not enabled is refused and raises a one-cycle watchdog reset request. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `halt_seq`

## Requirements
- R1: A halt is requested only when `instr_valid` is 1 and `instr_byte` equals 8'h8E while the CPU runs; any other byte leaves `cpu_stall` at 0.
- R2: Active-halt is chosen when `lt_irq_en` is 1, or when `ovf_irq_en` is 1 and `clk_sel` is 2'b01; every other combination gives plain halt.
- R3: Clock enables: running, `osc_en`, `timer_en` and every `periph_en` bit are 1; in active-halt only `osc_en` and `timer_en` are 1; in plain halt all are 0; during the start-up delay only `osc_en` is 1.
- R4: `i_mask` is 1 after reset, becomes 0 in the cycle after an accepted halt request, and while running takes `mask_wd` in the cycle after `mask_we` is 1.
- R5: If a qualifying interrupt is already pending with the halt request, `cpu_stall` stays 0, `i_mask` is cleared and a resume is reported in the next cycle.
- R6: Qualifying interrupts are the `irq_req` bits set in EXT_MASK (default 8'h0F) for plain halt, and those set in EXT_MASK or TMR_MASK (default 8'h30) for active-halt; other bits have no effect on a halt.
- R7: An interrupt exit drops `cpu_stall` one cycle after the request appears, with `resume` pulsed for one cycle, `resume_rst` 0 and `resume_idx` the lowest-numbered qualifying bit.
- R8: After reset is released, `cpu_stall` stays 1 for 256 cycles when `dly_long` is 0 and 4096 when it is 1 (counted from the first clock edge with reset high), then falls together with a `resume` pulse with `resume_rst` 1.
- R9: A halt request with `wdg_active` 1 and active-halt not chosen gives a one-cycle `wdg_rst` pulse in the next cycle, no stall and no change to `i_mask`; with active-halt chosen the halt proceeds and `wdg_rst` stays 0.
- R10: `cpu_stall` rises in the cycle after an accepted halt request that has no qualifying interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is a reset exit |
| instr_valid | input | 1 | `instr_byte` holds a decoded opcode this cycle |
| instr_byte | input | 8 | Opcode from the CPU decoder |
| lt_irq_en | input | 1 | Lite-timer interrupt enable |
| ovf_irq_en | input | 1 | Reload-timer overflow interrupt enable |
| clk_sel | input | 2 | Reload-timer clock select |
| dly_long | input | 1 | 1 selects the long start-up delay |
| wdg_active | input | 1 | Watchdog is running |
| irq_req | input | NIRQ | Interrupt requests |
| mask_we | input | 1 | CPU writes the interrupt mask |
| mask_wd | input | 1 | Value written to the mask |
| osc_en | output | 1 | Oscillator clock enable |
| timer_en | output | 1 | Wake-up timer clock enable |
| periph_en | output | NPER | Peripheral clock enables |
| cpu_stall | output | 1 | Holds the CPU |
| i_mask | output | 1 | CPU interrupt mask |
| resume | output | 1 | One-cycle pulse when the CPU is freed |
| resume_rst | output | 1 | With `resume`: 1 fetch reset vector, 0 service interrupt |
| resume_idx | output | $clog2(NIRQ) | With `resume`: index of the waking interrupt |
| wdg_rst | output | 1 | One-cycle watchdog reset request |

## Verification
Every result except the start-up delay is due one clock after its cause: stall, clock enables, mask and watchdog request follow a halt request on the next edge, and an interrupt exit shows on the next edge after the request. The bench drives inputs on the falling edge and samples exactly one falling edge later, so each check looks at the first cycle in which the result must be visible. For the start-up delay it counts falling-edge samples with the stall high after reset release and compares with 256 or 4096, checking the reset-vector resume in the sample where the stall falls.

// File: rtl/halt_pkg.sv
package halt_pkg;
  localparam logic [7:0] HALT_OPCODE = 8'h8E;

  typedef enum logic [2:0] {
    ST_LOAD  = 3'd0,
    ST_DELAY = 3'd1,
    ST_RUN   = 3'd2,
    ST_PHALT = 3'd3,
    ST_AHALT = 3'd4
  } halt_state_t;
endpackage

// File: rtl/halt_mode_sel.sv
module halt_mode_sel (
  input  logic       lt_irq_en,
  input  logic       ovf_irq_en,
  input  logic [1:0] clk_sel,
  output logic       ah_en
);
  always_comb begin
    ah_en = lt_irq_en | (ovf_irq_en & (clk_sel == 2'b01));
  end
endmodule

// File: rtl/halt_wake_pick.sv
module halt_wake_pick #(
  parameter int NIRQ = 8,
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic [NIRQ-1:0] req,
  output logic            any,
  output logic [IW-1:0]   idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/halt_boot_timer.sv
module halt_boot_timer #(
  parameter int SHORT_CYC = 256,
  parameter int LONG_CYC  = 4096,
  localparam int CW = $clog2(LONG_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  input  logic run,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= long_sel ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/halt_seq.sv
module halt_seq
  import halt_pkg::*;
#(
  parameter int               NIRQ      = 8,
  parameter int               NPER      = 4,
  parameter logic [NIRQ-1:0]  EXT_MASK  = 8'h0F,
  parameter logic [NIRQ-1:0]  TMR_MASK  = 8'h30,
  parameter int               SHORT_CYC = 256,
  parameter int               LONG_CYC  = 4096,
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [7:0]      instr_byte,
  input  logic            lt_irq_en,
  input  logic            ovf_irq_en,
  input  logic [1:0]      clk_sel,
  input  logic            dly_long,
  input  logic            wdg_active,
  input  logic [NIRQ-1:0] irq_req,
  input  logic            mask_we,
  input  logic            mask_wd,
  output logic            osc_en,
  output logic            timer_en,
  output logic [NPER-1:0] periph_en,
  output logic            cpu_stall,
  output logic            i_mask,
  output logic            resume,
  output logic            resume_rst,
  output logic [IW-1:0]   resume_idx,
  output logic            wdg_rst
);
  halt_state_t     st;
  logic            ah_en;
  logic            halt_hit;
  logic            wdg_trip;
  logic            use_timer_src;
  logic [NIRQ-1:0] wake_req;
  logic            wake_any;
  logic [IW-1:0]   wake_idx;
  logic            boot_done;

  halt_mode_sel u_mode (
    .lt_irq_en (lt_irq_en),
    .ovf_irq_en(ovf_irq_en),
    .clk_sel   (clk_sel),
    .ah_en     (ah_en)
  );

  assign halt_hit = (st == ST_RUN) && instr_valid && (instr_byte == HALT_OPCODE);
  assign wdg_trip = halt_hit && wdg_active && !ah_en;

  assign use_timer_src = (st == ST_AHALT) || ((st == ST_RUN) && ah_en);
  assign wake_req = irq_req & (use_timer_src ? (EXT_MASK | TMR_MASK) : EXT_MASK);

  halt_wake_pick #(.NIRQ(NIRQ)) u_pick (
    .req(wake_req),
    .any(wake_any),
    .idx(wake_idx)
  );

  halt_boot_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_boot (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (st == ST_LOAD),
    .long_sel(dly_long),
    .run     (st == ST_DELAY),
    .done    (boot_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_LOAD;
      i_mask     <= 1'b1;
      resume     <= 1'b0;
      resume_rst <= 1'b0;
      resume_idx <= '0;
      wdg_rst    <= 1'b0;
    end else begin
      resume  <= 1'b0;
      wdg_rst <= 1'b0;
      unique case (st)
        ST_LOAD: st <= ST_DELAY;
        ST_DELAY: begin
          if (boot_done) begin
            st         <= ST_RUN;
            resume     <= 1'b1;
            resume_rst <= 1'b1;
            resume_idx <= '0;
          end
        end
        ST_RUN: begin
          if (wdg_trip) begin
            wdg_rst <= 1'b1;
          end else if (halt_hit) begin
            i_mask <= 1'b0;
            if (wake_any) begin
              resume     <= 1'b1;
              resume_rst <= 1'b0;
              resume_idx <= wake_idx;
            end else begin
              st <= ah_en ? ST_AHALT : ST_PHALT;
            end
          end else if (mask_we) begin
            i_mask <= mask_wd;
          end
        end
        ST_PHALT, ST_AHALT: begin
          if (wake_any) begin
            st         <= ST_RUN;
            resume     <= 1'b1;
            resume_rst <= 1'b0;
            resume_idx <= wake_idx;
          end
        end
        default: st <= ST_LOAD;
      endcase
    end
  end

  assign osc_en    = (st != ST_PHALT);
  assign timer_en  = (st == ST_RUN) || (st == ST_AHALT);
  assign periph_en = (st == ST_RUN) ? {NPER{1'b1}} : {NPER{1'b0}};
  assign cpu_stall = (st != ST_RUN);
endmodule

// File: rtl/halt_seq_chk.sv
module halt_seq_chk #(
  parameter int NPER = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            osc_en,
  input logic            timer_en,
  input logic [NPER-1:0] periph_en,
  input logic            cpu_stall,
  input logic            i_mask,
  input logic            resume,
  input logic            wdg_rst
);
  AST_RUN_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stall |-> (osc_en && timer_en && (&periph_en))); // R3

  AST_HALT_NO_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> (periph_en == '0)); // R3

  AST_TIMER_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    timer_en |-> osc_en); // R3

  AST_ENTRY_UNMASKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> !i_mask); // R4

  AST_RESUME_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> !cpu_stall); // R7

  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume); // R7

  AST_WDG_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |-> (!cpu_stall && !resume)); // R9

  AST_WDG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |=> !wdg_rst); // R9
endmodule

bind halt_seq halt_seq_chk #(.NPER(NPER)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .osc_en   (osc_en),
  .timer_en (timer_en),
  .periph_en(periph_en),
  .cpu_stall(cpu_stall),
  .i_mask   (i_mask),
  .resume   (resume),
  .wdg_rst  (wdg_rst)
);

// File: tb/halt_seq_test.sv
module halt_seq_test;
  localparam int NIRQ = 8;
  localparam int NPER = 4;
  localparam logic [7:0] EXT = 8'h0F;
  localparam logic [7:0] TMR = 8'h30;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [7:0]      instr_byte = 8'h00;
  logic            lt_irq_en = 1'b0;
  logic            ovf_irq_en = 1'b0;
  logic [1:0]      clk_sel = 2'b00;
  logic            dly_long = 1'b0;
  logic            wdg_active = 1'b0;
  logic [NIRQ-1:0] irq_req = '0;
  logic            mask_we = 1'b0;
  logic            mask_wd = 1'b0;
  logic            osc_en, timer_en, cpu_stall, i_mask, resume, resume_rst, wdg_rst;
  logic [NPER-1:0] periph_en;
  logic [2:0]      resume_idx;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  halt_seq uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_byte(instr_byte),
    .lt_irq_en(lt_irq_en), .ovf_irq_en(ovf_irq_en), .clk_sel(clk_sel),
    .dly_long(dly_long), .wdg_active(wdg_active), .irq_req(irq_req),
    .mask_we(mask_we), .mask_wd(mask_wd), .osc_en(osc_en), .timer_en(timer_en),
    .periph_en(periph_en), .cpu_stall(cpu_stall), .i_mask(i_mask),
    .resume(resume), .resume_rst(resume_rst), .resume_idx(resume_idx),
    .wdg_rst(wdg_rst)
  );

  function automatic bit ah_exp(bit lt, bit ovf, logic [1:0] sel);
    return lt | (ovf & (sel == 2'b01));
  endfunction

  function automatic logic [7:0] src_exp(bit ah);
    return ah ? (EXT | TMR) : EXT;
  endfunction

  function automatic int low_exp(logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) low_exp = i;
  endfunction

  function automatic int clk_exp(bit stalled, bit ah);
    // packed {osc, timer, periph}
    if (!stalled) return 6'b111111;
    return ah ? 6'b110000 : 6'b000000;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit lng);
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    dly_long = lng;
    irq_req = '0;
    instr_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(cpu_stall && i_mask && osc_en && !timer_en && periph_en == '0,
          "R3 reset state", {cpu_stall, i_mask, osc_en, timer_en, periph_en}, 8'hE0);
    rst_n = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      if (!cpu_stall) break;
      n++;
      if (n == 1) check(osc_en && !timer_en && periph_en == '0, "R3 delay clocks",
                        {osc_en, timer_en, periph_en}, 6'b100000);
    end
    check(n == (lng ? 4096 : 256), "R8 delay length", n, lng ? 4096 : 256);
    check(resume && resume_rst, "R8 reset vector", {resume, resume_rst}, 2'b11);
    check(i_mask, "R4 mask after reset", i_mask, 1);
  endtask

  task automatic set_mask(bit v);
    mask_we = 1'b1;
    mask_wd = v;
    @(negedge clk);
    mask_we = 1'b0;
    check(i_mask == v, "R4 mask write", i_mask, v);
  endtask

  // Issue a halt with the given configuration and pending irq; follow to completion.
  task automatic halt_run(bit lt, bit ovf, logic [1:0] sel, bit wdg, logic [7:0] pend,
                          logic [7:0] late, string tag);
    bit ah;
    bit m0;
    logic [7:0] q;
    ah = ah_exp(lt, ovf, sel);
    m0 = i_mask;
    lt_irq_en = lt; ovf_irq_en = ovf; clk_sel = sel; wdg_active = wdg;
    irq_req = pend;
    instr_valid = 1'b1; instr_byte = 8'h8E;
    @(negedge clk);
    instr_valid = 1'b0;
    irq_req = '0;
    if (wdg && !ah) begin
      check(wdg_rst && !cpu_stall && i_mask == m0, {"R9 refused ", tag},
            {wdg_rst, cpu_stall, i_mask}, {1'b1, 1'b0, m0});
      return;
    end
    check(!wdg_rst, {"R9 no wdg reset ", tag}, wdg_rst, 0);
    check(!i_mask, {"R4 mask cleared ", tag}, i_mask, 0);
    q = pend & src_exp(ah);
    if (q != 0) begin
      check(!cpu_stall && resume && !resume_rst && resume_idx == low_exp(q),
            {"R5 pending wake ", tag}, {cpu_stall, resume, resume_rst, resume_idx},
            {3'b010, 3'(low_exp(q))});
      return;
    end
    check(cpu_stall, {"R10 stall ", tag}, cpu_stall, 1);
    check({osc_en, timer_en, periph_en} == clk_exp(1, ah), {"R2 R3 flavour clocks ", tag},
          {osc_en, timer_en, periph_en}, clk_exp(1, ah));
    // non-qualifying requests first
    irq_req = late & ~src_exp(ah);
    if (irq_req != 0) begin
      repeat (3) @(negedge clk);
      check(cpu_stall && !resume, {"R6 ignored irq ", tag}, cpu_stall, 1);
    end
    q = late & src_exp(ah);
    if (q == 0) q = 8'h08;
    irq_req = q | (late & ~src_exp(ah));
    @(negedge clk);
    irq_req = '0;
    check(!cpu_stall && resume && !resume_rst && resume_idx == low_exp(q),
          {"R7 irq exit ", tag}, {cpu_stall, resume, resume_rst, resume_idx},
          {3'b010, 3'(low_exp(q))});
    @(negedge clk);
    check(!resume && {osc_en, timer_en, periph_en} == clk_exp(0, ah),
          {"R3 R7 run after exit ", tag}, {resume, osc_en, timer_en, periph_en},
          {1'b0, 6'(clk_exp(0, ah))});
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset(1'b0);
    do_reset(1'b1);
    do_reset(1'b0);

    // R1: other opcodes are not halts
    instr_valid = 1'b1; instr_byte = 8'h8F;
    @(negedge clk);
    instr_byte = 8'h8E; instr_valid = 1'b0;
    @(negedge clk);
    check(!cpu_stall && i_mask, "R1 non-halt ignored", {cpu_stall, i_mask}, 2'b01);

    halt_run(0, 0, 2'b00, 0, 8'h00, 8'h30, "plain");
    set_mask(1'b1);
    halt_run(1, 0, 2'b10, 0, 8'h00, 8'hC0, "lt active");
    halt_run(0, 1, 2'b01, 0, 8'h00, 8'h20, "ovf active");
    halt_run(0, 1, 2'b11, 0, 8'h00, 8'h10, "ovf wrong sel");
    set_mask(1'b1);
    halt_run(0, 0, 2'b00, 0, 8'h06, 8'h00, "pending ext");
    halt_run(0, 0, 2'b00, 0, 8'h10, 8'h01, "pending tmr plain");
    set_mask(1'b1);
    halt_run(0, 0, 2'b01, 1, 8'h00, 8'h00, "wdg plain");
    set_mask(1'b0);
    halt_run(0, 1, 2'b10, 1, 8'h00, 8'h00, "wdg wrong sel");
    halt_run(1, 0, 2'b00, 1, 8'h00, 8'h10, "wdg active");

    for (int it = 0; it < 60; it++) begin
      logic [7:0] p, l;
      p = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      l = 8'($urandom);
      set_mask(1'($urandom));
      halt_run(1'($urandom), 1'($urandom), 2'($urandom), ($urandom % 4 == 0), p, l, "random");
      @(negedge clk);
    end

    do_reset(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule